// File: doc/BRIEF.md
# Parallel-to-Serial Word Transmitter

This block turns 16-bit parallel words into one serial bit stream, one bit per cycle of a fast bit clock. It runs entirely in the bit-clock domain. A free-running bit counter divides the bit clock by 16 and produces a word-rate clock for the upstream source, plus a one-cycle acceptance window. Each accepted word is loaded into a shift register in the same cycle that the last bit of the previous word leaves, so the stream has no gaps.

A static order input picks which end of the word goes out first. An active-low squelch input forces the serial output to zero without disturbing the shift state, so clean data resumes on the same word boundaries. A disable input stops the forwarded copy of the bit clock.

The word input is a valid/ready stream. The rules for back-pressure are these. `s_ready` is high for exactly one cycle in every 16. A word transfers on a rising edge where both `s_valid` and `s_ready` are high. Until then the source must hold `s_data` and `s_valid` steady. If `s_valid` is low in the acceptance cycle, the block sends an all-zero word rather than stalling the line.

Top module: `word_serializer`

## Requirements
- R1: `wclk_o` has a period of exactly 16 bit-clock cycles. It is high for 8 cycles and low for 8. It rises in the cycle that carries the first bit of each word slot.
- R2: `s_ready` is high for exactly one cycle in every 16, namely the cycle that carries the final bit of the current word. A word is taken on the rising edge where `s_valid` and `s_ready` are both high.
- R3: If `s_valid` is low on the acceptance edge, the next 16 serial bits are all 0.
- R4: With `msb_first` = 0 at the acceptance edge, the word goes out as bit 0 first, then bits 1 up to 15.
- R5: With `msb_first` = 1 at the acceptance edge, the word goes out as bit 15 first, then bits 14 down to 0.
- R6: The first bit of an accepted word is on `ser_o` in the cycle right after the acceptance edge. Consecutive words leave no idle cycle between them.
- R7: While `squelch_n` is 0, `ser_o` is 0 in that same cycle, whatever the word holds.
- R8: Squelch does not alter the shift state or the bit count. After `squelch_n` returns to 1, `ser_o` carries the bit that belongs to that position of the current word.
- R9: While `clk_dis` is 1, `fclk_o` stays low. While it is 0, `fclk_o` follows `clk`. A change takes effect from the next falling edge of `clk`.
- R10: `rst_n` is a synchronous active-low reset. During reset and after it, `s_ready` is 0, `wclk_o` is 1 and `fclk_o` is 0. `ser_o` stays 0 until the first word has been loaded, which happens at the 16th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Source has a word on `s_data` |
| s_ready | output | 1 | Acceptance window, one cycle in 16 |
| s_data | input | 16 | Parallel word |
| msb_first | input | 1 | 0: bit 0 first; 1: bit 15 first |
| squelch_n | input | 1 | Active-low force of `ser_o` to 0 |
| clk_dis | input | 1 | 1 stops the forwarded bit clock |
| ser_o | output | 1 | Serial data |
| wclk_o | output | 1 | Divide-by-16 word clock for the source |
| fclk_o | output | 1 | Gated copy of the bit clock |

## Verification
Two events can fall in one cycle: squelch held low and the word reload with its `s_ready` window. The bench drives squelch pulses of random length across acceptance edges, both with and without a valid word, and toggles the order input in those same cycles. A bench model keeps the bit position and the loaded word independently of squelch. Every cycle it checks that `ser_o` is forced low while squelch is active. It also checks that, after release, the output carries exactly the bit of the new word that the position calls for, and that neither the word clock nor the acceptance window moved.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic {
    ORD_LSB_FIRST = 1'b0,
    ORD_MSB_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/ws_bitcount.sv
module ws_bitcount #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_o,
  output logic wclk_o,
  output logic [$clog2(W)-1:0] pos_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] HALF = CW'(W / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign last_o = (cnt == LAST);
  assign wclk_o = (cnt < HALF);
  assign pos_o  = cnt;

  // R1: counter returns to zero right after the final position
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> (cnt == '0));
  // R2: the acceptance window never lasts two cycles
  p_window_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);
  // R1: word clock rises only after the final slot position
  p_wclk_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wclk_o) |-> $past(last_o));
endmodule

// File: rtl/ws_shifter.sv
module ws_shifter
  import ws_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         take_i,
  input  logic [W-1:0] data_i,
  input  order_e       order_i,
  output logic         bit_o
);
  logic [W-1:0] sr;
  logic [W-1:0] rev;
  logic [W-1:0] nxt;

  for (genvar gi = 0; gi < W; gi++) begin : g_rev
    assign rev[gi] = data_i[W-1-gi];
  end

  always_comb begin
    if (!take_i)                       nxt = '0;
    else if (order_i == ORD_MSB_FIRST) nxt = rev;
    else                               nxt = data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sr <= '0;
    else if (load_i) sr <= nxt;
    else             sr <= {1'b0, sr[W-1:1]};
  end

  assign bit_o = sr[0];

  // R6: between loads the register only moves one place toward the output
  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (sr == ($past(sr) >> 1)));
  // R4: low-first order puts bit 0 on the output first
  p_lsb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && take_i && order_i == ORD_LSB_FIRST) |=> (bit_o == $past(data_i[0])));
  // R5: high-first order puts the top bit on the output first
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && take_i && order_i == ORD_MSB_FIRST) |=> (bit_o == $past(data_i[W-1])));
  // R3: a missing word loads an idle pattern
  p_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !take_i) |=> (sr == '0));
endmodule

// File: rtl/ws_clkgate.sv
module ws_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_i,
  output logic fclk_o
);
  logic en;

  // enable changes only while clk is low, so the gated clock has no runt pulse
  always_ff @(negedge clk) begin
    if (!rst_n) en <= 1'b0;
    else        en <= !dis_i;
  end

  assign fclk_o = clk & en;

  // R9: a disable level held across a cycle is reflected in the gate
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dis_i) |-> (en == !dis_i));
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import ws_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         msb_first,
  input  logic         squelch_n,
  input  logic         clk_dis,
  output logic         ser_o,
  output logic         wclk_o,
  output logic         fclk_o
);
  localparam int CW = $clog2(W);

  logic          last;
  logic [CW-1:0] pos;
  logic          raw_bit;
  order_e        ord;

  assign ord = msb_first ? ORD_MSB_FIRST : ORD_LSB_FIRST;

  ws_bitcount #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .last_o (last),
    .wclk_o (wclk_o),
    .pos_o  (pos)
  );

  ws_shifter #(.W(W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (last),
    .take_i  (s_valid),
    .data_i  (s_data),
    .order_i (ord),
    .bit_o   (raw_bit)
  );

  ws_clkgate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .dis_i  (clk_dis),
    .fclk_o (fclk_o)
  );

  assign s_ready = last;
  assign ser_o   = raw_bit & squelch_n;

  // R6: bit position restarts right after a transfer
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (pos == '0));
  // R2: window and word clock low phase coincide
  p_window_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !wclk_o);
endmodule

// File: tb/sim_word_serializer.sv
`timescale 1ns/100ps
module sim_word_serializer;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, s_valid, s_ready, msb_first, squelch_n, clk_dis;
  logic ser_o, wclk_o, fclk_o;
  logic [W-1:0] s_data;

  word_serializer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .msb_first(msb_first), .squelch_n(squelch_n),
    .clk_dis(clk_dis), .ser_o(ser_o), .wclk_o(wclk_o), .fclk_o(fclk_o)
  );

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  logic [W-1:0] mseq = '0;
  bit loaded = 0;
  bit last_take = 0;
  bit last_msb = 0;
  bit sq_seen = 0;
  bit accepted = 0;
  bit prev_dis = 0;
  bit dis_changed = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] send_order(input logic [W-1:0] w, input logic msb);
    logic [W-1:0] s;
    for (int k = 0; k < W; k++) s[k] = msb ? w[W-1-k] : w[k];
    return s;
  endfunction

  // advance one clock: update model with inputs held before the edge
  task automatic edge_model();
    @(posedge clk);
    accepted = 0;
    if (mcnt == W - 1) begin
      accepted  = s_valid;
      last_take = s_valid;
      last_msb  = msb_first;
      mseq      = s_valid ? send_order(s_data, msb_first) : '0;
      loaded    = 1;
      sq_seen   = 0;
      mcnt      = 0;
    end else begin
      mcnt++;
    end
    #0.5;
  endtask

  task automatic check_outputs();
    string tag;
    logic exp_ser;
    #0.5;
    chk(s_ready == (mcnt == W - 1), "R2 ready window", 32'(s_ready), 32'(mcnt == W - 1));
    chk(wclk_o == (mcnt < W / 2), "R1 word clock", 32'(wclk_o), 32'(mcnt < W / 2));
    if (!squelch_n) sq_seen = 1;
    exp_ser = squelch_n ? mseq[mcnt] : 1'b0;
    if (!loaded)              tag = "R10 idle before first load";
    else if (!squelch_n)      tag = "R7 squelch";
    else if (sq_seen)         tag = "R8 resume after squelch";
    else if (!last_take)      tag = "R3 underrun zeros";
    else if (mcnt == 0)       tag = "R6 first bit";
    else if (last_msb)        tag = "R5 high first";
    else                      tag = "R4 low first";
    chk(ser_o == exp_ser, tag, 32'(ser_o), 32'(exp_ser));
    if (!dis_changed)
      chk(fclk_o == !clk_dis, "R9 forwarded clock high phase", 32'(fclk_o), 32'(!clk_dis));
  endtask

  task automatic drive_dis(input bit d);
    dis_changed = (d != prev_dis);
    clk_dis = d;
    prev_dis = d;
  endtask

  task automatic step_directed();
    edge_model();
    drive_dis(clk_dis);
    check_outputs();
  endtask

  task automatic step_random();
    edge_model();
    if (accepted || !s_valid) begin
      s_data  = W'($urandom);
      s_valid = ($urandom % 4) != 0;
    end
    if (($urandom % 13) == 0) msb_first = ~msb_first;
    if (!squelch_n) squelch_n = ($urandom % 3) == 0;
    else            squelch_n = ($urandom % 10) != 0;
    drive_dis(($urandom % 50) == 0 ? ~clk_dis : clk_dis);
    check_outputs();
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 0; s_valid = 0; s_data = '0; msb_first = 0; squelch_n = 1; clk_dis = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(ser_o == 1'b0, "R10 ser in reset", 32'(ser_o), 0);
    chk(s_ready == 1'b0, "R10 ready in reset", 32'(s_ready), 0);
    chk(wclk_o == 1'b1, "R10 word clock in reset", 32'(wclk_o), 1);
    chk(fclk_o == 1'b0, "R10 forwarded clock in reset", 32'(fclk_o), 0);
    rst_n = 1;
    mcnt = 0;
    // first word, low-first, offered immediately: output idle until load (R10)
    s_valid = 1; s_data = 16'hA5C3; msb_first = 0;
    for (int i = 0; i < W + W; i++) begin
      edge_model();
      if (accepted) begin s_data = 16'h8001; msb_first = 1; end
      drive_dis(0);
      check_outputs();
    end
    // R5 with asymmetric word, then R3 underrun
    s_data = 16'hF00D; msb_first = 1;
    for (int i = 0; i < W; i++) begin
      edge_model();
      if (accepted) s_valid = 0;
      drive_dis(0);
      check_outputs();
    end
    for (int i = 0; i < W; i++) step_directed();
    // R7/R8: squelch mid-word on an all-ones word, and across a reload
    s_valid = 1; s_data = 16'hFFFF; msb_first = 0;
    for (int i = 0; i < 3 * W; i++) begin
      edge_model();
      squelch_n = !((mcnt >= 3 && mcnt <= 7) || mcnt == W - 1 || (i > 2 * W && mcnt == 0));
      drive_dis(0);
      check_outputs();
    end
    squelch_n = 1;
    // R9: disable and re-enable the forwarded clock
    edge_model(); drive_dis(1); check_outputs();
    step_directed(); step_directed();
    @(negedge clk); #0.5;
    chk(fclk_o == 1'b0, "R9 forwarded clock low phase", 32'(fclk_o), 0);
    edge_model(); drive_dis(0); check_outputs();
    step_directed(); step_directed();
    // random mix
    for (int i = 0; i < 4000; i++) step_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule